// File: doc/BRIEF.md
# Multi-Output System Clock Divider Bank

This block takes one full-rate clock and produces eleven clock-enable strobes. Each strobe is high for one cycle of the input clock once in every period of its output, and the period length is that output's divide ratio. The strobes are intended as enables for logic that runs at a fraction of the system rate. Eight outputs have fixed ratios. Outputs 2, 5 and 8 can be given a new ratio through a small write port. Software can switch outputs 2 and 5 off. A sync input restarts every divider counter at the same moment, which brings the fixed outputs back into a known phase relation.

A new ratio is held as pending until the running period of that output ends, so no output ever produces a period that is neither its old nor its new length. Each programmable output checks its ratio against its own legal range. For output 5, that range comes from parameters that set the input frequency and the highest and lowest allowed output frequency. A write outside the range changes nothing and sets a sticky error flag. The select lines also drive a read-back path, which returns the active ratio and the gate state of the output they select.

Top module: `clkdiv_bank`

## Requirements
- R1: `clk_en[0]` (output 1) is high on every cycle once reset has been released.
- R2: The fixed outputs pulse once in every N cycles, where N is 2 for output 3, 3 for output 4, 64 for output 6, 6 for output 7, 12 for output 9, 3 for output 10 and 6 for output 11. Output n drives `clk_en[n-1]`.
- R3: After reset, outputs 2, 5 and 8 divide by 3, 5 and 64. No output is gated off and `err` is low. All counters start at zero, so every strobe is high in the first cycle after reset is released.
- R4: The legal ratios are 1 to 32 for output 2 and 24 to 80 for output 8. For output 5 they run from ceil(IN_FREQ_MHZ/OUT5_FMAX_MHZ) to floor(IN_FREQ_MHZ/OUT5_FMIN_MHZ), which is 5 to 31 with the default parameters.
- R5: If `wr_en` selects output 2, 5 or 8 with an illegal ratio, the write is ignored as a whole: neither the ratio nor the gate changes. `err` goes high and stays high until reset.
- R6: A write whose `wr_sel` is anything other than 2, 5 or 8 has no effect on any ratio or gate, and it does not set `err`.
- R7: A legal write to output 2 or 5 loads `wr_off` as that output's gate. While the gate is 1 the output's strobe stays low. Clearing the gate brings the pulses back at the same ratio. For output 8, `wr_off` is ignored.
- R8: A new ratio takes effect at the end of the period that is running when it is written. Every gap between pulses equals either the old ratio or the new one.
- R9: A one-cycle pulse on `sync` resets every counter. In the next cycle every output that is not gated is high, and in the cycle after that only outputs with ratio 1 are high.
- R10: `rd_ratio` and `rd_off` show the active ratio and the gate of the output that `wr_sel` selects (values 1 to 11). Fixed outputs return their fixed ratio with a gate of 0. Any other select value returns 0 on both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Restarts every divider counter |
| wr_en | input | 1 | Write strobe for the ratio and gate settings |
| wr_sel | input | 4 | Selects an output (1 to 11) for writes and read-back |
| wr_ratio | input | 7 | Requested divide ratio |
| wr_off | input | 1 | Requested gate state (1 = off) |
| clk_en | output | 11 | Enable strobes; bit n-1 belongs to output n |
| rd_ratio | output | 7 | Active ratio of the selected output |
| rd_off | output | 1 | Gate state of the selected output |
| err | output | 1 | Sticky flag for a rejected ratio |

## Verification
A counter that is off by one, or that wraps at the wrong value, changes the spacing between pulses on that output. This shows up within one period of the output, which is at most 80 cycles. If a pending ratio is applied too early, the bench sees a gap that is neither the old ratio nor the new one, right after the write. A range check with the wrong limit shows up at once: `err` takes the wrong value, and `rd_ratio` shows the wrong value one period later. After a sync pulse, any counter that fails to restart breaks the all-high pattern on the very next cycle.

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
  parameter int IN_FREQ_MHZ   = 1000,
  parameter int OUT5_FMAX_MHZ = 210,
  parameter int OUT5_FMIN_MHZ = 32,
  parameter int OUT2_DEF      = 3,
  parameter int OUT2_MAX      = 32,
  parameter int OUT5_DEF      = 5,
  parameter int OUT8_DEF      = 64,
  parameter int OUT8_MIN      = 24,
  parameter int OUT8_MAX      = 80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [6:0]  wr_ratio,
  input  logic        wr_off,
  output logic [10:0] clk_en,
  output logic [6:0]  rd_ratio,
  output logic        rd_off,
  output logic        err
);
  localparam int NOUT    = 11;
  localparam int RMAX    = 127;
  localparam int O5_MIN  = (IN_FREQ_MHZ + OUT5_FMAX_MHZ - 1) / OUT5_FMAX_MHZ;
  localparam int O5_RAW  = IN_FREQ_MHZ / OUT5_FMIN_MHZ;
  localparam int O5_MAX  = (O5_RAW > RMAX) ? RMAX : O5_RAW;

  function automatic logic [6:0] base_div(input int i);
    case (i)
      0:       return 7'(1);
      1:       return 7'(OUT2_DEF);
      2:       return 7'(2);
      3:       return 7'(3);
      4:       return 7'(OUT5_DEF);
      5:       return 7'(64);
      6:       return 7'(6);
      7:       return 7'(OUT8_DEF);
      8:       return 7'(12);
      9:       return 7'(3);
      default: return 7'(6);
    endcase
  endfunction

  logic [6:0]      act [NOUT];
  logic [6:0]      cnt [NOUT];
  logic [NOUT-1:0] off;
  logic [NOUT-1:0] wrap;
  logic            legal, prog_sel, wr_ok;

  assign prog_sel = (wr_sel == 4'd2) || (wr_sel == 4'd5) || (wr_sel == 4'd8);

  always_comb begin
    case (wr_sel)
      4'd2:    legal = (wr_ratio >= 7'd1) && (int'(wr_ratio) <= OUT2_MAX);
      4'd5:    legal = (int'(wr_ratio) >= O5_MIN) && (int'(wr_ratio) <= O5_MAX);
      4'd8:    legal = (int'(wr_ratio) >= OUT8_MIN) && (int'(wr_ratio) <= OUT8_MAX);
      default: legal = 1'b0;
    endcase
  end

  assign wr_ok = wr_en && prog_sel && legal;

  always_ff @(posedge clk) begin
    if (!rst_n)                         err <= 1'b0;
    else if (wr_en && prog_sel && !legal) err <= 1'b1;
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    localparam logic [6:0] BASE = base_div(i);
    localparam bit PROG  = (i == 1) || (i == 4) || (i == 7);
    localparam bit GATED = (i == 1) || (i == 4);
    logic [6:0] cnt_q;

    assign wrap[i]   = (cnt_q == act[i] - 7'd1);
    assign cnt[i]    = cnt_q;
    assign clk_en[i] = (cnt_q == 7'd0) && !off[i];

    always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= 7'd0;
      else if (sync || wrap[i]) cnt_q <= 7'd0;
      else                     cnt_q <= cnt_q + 7'd1;
    end

    if (PROG) begin : g_prog
      logic [6:0] act_q, pend_q;
      logic       pv_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          act_q  <= BASE;
          pend_q <= BASE;
          pv_q   <= 1'b0;
        end else begin
          if ((sync || wrap[i]) && pv_q) begin
            act_q <= pend_q;
            pv_q  <= 1'b0;
          end
          if (wr_ok && wr_sel == 4'(i + 1)) begin
            pend_q <= wr_ratio;
            pv_q   <= 1'b1;
          end
        end
      end
      assign act[i] = act_q;

      // R8
      cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < act_q);
    end else begin : g_fixed
      assign act[i] = BASE;
    end

    if (GATED) begin : g_gate
      logic off_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                           off_q <= 1'b0;
        else if (wr_ok && wr_sel == 4'(i + 1)) off_q <= wr_off;
      end
      assign off[i] = off_q;
    end else begin : g_nogate
      assign off[i] = 1'b0;
    end
  end

  always_comb begin
    rd_ratio = 7'd0;
    rd_off   = 1'b0;
    for (int k = 0; k < NOUT; k++) begin
      if (wr_sel == 4'(k + 1)) begin
        rd_ratio = act[k];
        rd_off   = off[k];
      end
    end
  end

  // R1
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en[0]);
  // R2
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en[2] && !sync) |=> !clk_en[2]);
  // R4
  out2_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act[1] >= 7'd1 && int'(act[1]) <= OUT2_MAX);
  // R4
  out5_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(act[4]) >= O5_MIN && int'(act[4]) <= O5_MAX);
  // R4
  out8_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(act[7]) >= OUT8_MIN && int'(act[7]) <= OUT8_MAX);
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R7
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 4'd2 && wr_off && wr_ratio >= 7'd1 && int'(wr_ratio) <= OUT2_MAX)
      |=> !clk_en[1]);
  // R9
  sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (clk_en[2] && clk_en[3] && clk_en[5] && clk_en[8]));
endmodule

// File: tb/clkdiv_bank_bench.sv
`timescale 1ns/1ps
module clkdiv_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = 4'd0;
  logic [6:0]  wr_ratio = 7'd0;
  logic        wr_off = 1'b0;
  logic [10:0] clk_en;
  logic [6:0]  rd_ratio;
  logic        rd_off;
  logic        err;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  clkdiv_bank u_clkdiv_bank (
    .clk(clk), .rst_n(rst_n), .sync(sync), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_ratio(wr_ratio), .wr_off(wr_off), .clk_en(clk_en), .rd_ratio(rd_ratio),
    .rd_off(rd_off), .err(err));

  // {select, expected read-back ratio after reset}
  localparam logic [10:0] RB_TAB [14] = '{
    {4'd1, 7'd1}, {4'd2, 7'd3}, {4'd3, 7'd2}, {4'd4, 7'd3}, {4'd5, 7'd5},
    {4'd6, 7'd64}, {4'd7, 7'd6}, {4'd8, 7'd64}, {4'd9, 7'd12}, {4'd10, 7'd3},
    {4'd11, 7'd6}, {4'd0, 7'd0}, {4'd12, 7'd0}, {4'd15, 7'd0}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int sel, input int ratio, input bit offv);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'(sel); wr_ratio = 7'(ratio); wr_off = offv;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic gap(input int idx, output int n);
    int lim = 0;
    @(negedge clk);
    while (!clk_en[idx] && lim < 300) begin @(negedge clk); lim++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!clk_en[idx] && n < 300);
  endtask

  task automatic readback(input int sel, output int r);
    wr_sel = 4'(sel);
    #0.5;
    r = rd_ratio;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int g, r;
    do_reset();
    #0.5;
    check(clk_en == 11'h7FF, "R3 first strobes", clk_en, 11'h7FF);
    check(err == 1'b0, "R3 err after reset", err, 0);
    @(negedge clk); #0.5;
    check(clk_en == 11'h001, "R1 second cycle", clk_en, 11'h001);

    foreach (RB_TAB[k]) begin
      wr_sel = RB_TAB[k][10:7];
      #0.5;
      check(rd_ratio == RB_TAB[k][6:0] && rd_off == 1'b0, "R10 read-back",
            rd_ratio, RB_TAB[k][6:0]);
    end

    gap(0, g); check(g == 1, "R1 gap", g, 1);
    gap(2, g); check(g == 2, "R2 out3", g, 2);
    gap(3, g); check(g == 3, "R2 out4", g, 3);
    gap(5, g); check(g == 64, "R2 out6", g, 64);
    gap(6, g); check(g == 6, "R2 out7", g, 6);
    gap(8, g); check(g == 12, "R2 out9", g, 12);
    gap(9, g); check(g == 3, "R2 out10", g, 3);
    gap(10, g); check(g == 6, "R2 out11", g, 6);
    gap(1, g); check(g == 3, "R3 out2 default", g, 3);
    gap(4, g); check(g == 5, "R3 out5 default", g, 5);
    gap(7, g); check(g == 64, "R3 out8 default", g, 64);

    // R8 ratio change on out2 from 3 to 7
    wr(2, 7, 0);
    for (int k = 0; k < 4; k++) begin
      gap(1, g);
      check(g == 3 || g == 7, "R8 transition gap", g, 7);
      if (k >= 2) check(g == 7, "R8 new ratio", g, 7);
    end
    readback(2, r); check(r == 7, "R10 active ratio", r, 7);

    // R4 bounds and R5 rejects
    wr(2, 32, 0); repeat (40) @(negedge clk);
    readback(2, r); check(r == 32, "R4 out2 max", r, 32);
    check(err == 0, "R4 legal no err", err, 0);
    wr(2, 0, 1); repeat (40) @(negedge clk);
    readback(2, r); check(r == 32, "R5 out2 zero kept", r, 32);
    check(err == 1, "R5 err set", err, 1);
    check(rd_off == 0, "R5 gate untouched", rd_off, 0);
    gap(1, g); check(g == 32, "R5 out2 still pulses", g, 32);
    wr(2, 33, 0); repeat (40) @(negedge clk);
    readback(2, r); check(r == 32, "R5 out2 33 rejected", r, 32);
    wr(2, 1, 0); repeat (40) @(negedge clk);
    readback(2, r); check(r == 1, "R4 out2 min", r, 1);
    check(err == 1, "R5 err sticky", err, 1);
    do_reset(); @(negedge clk);
    check(err == 0, "R5 err cleared by reset", err, 0);

    wr(8, 23, 0); readback(8, r); check(err == 1, "R4 out8 23 illegal", err, 1);
    do_reset(); @(negedge clk);
    wr(8, 81, 0); check(err == 1, "R4 out8 81 illegal", err, 1);
    do_reset(); @(negedge clk);
    wr(8, 24, 0); repeat (70) @(negedge clk);
    readback(8, r); check(r == 24, "R4 out8 min", r, 24);
    gap(7, g); check(g == 24, "R4 out8 gap", g, 24);
    wr(8, 80, 0); repeat (30) @(negedge clk);
    readback(8, r); check(r == 80, "R4 out8 max", r, 80);
    wr(5, 4, 0); check(err == 1, "R4 out5 4 illegal", err, 1);
    do_reset(); @(negedge clk);
    wr(5, 32, 0); check(err == 1, "R4 out5 32 illegal", err, 1);
    do_reset(); @(negedge clk);
    wr(5, 31, 0); repeat (10) @(negedge clk);
    readback(5, r); check(r == 31, "R4 out5 max", r, 31);
    check(err == 0, "R4 out5 31 legal", err, 0);
    wr(5, 5, 0); repeat (40) @(negedge clk);
    readback(5, r); check(r == 5, "R4 out5 min", r, 5);

    // R6 writes to other selects
    do_reset(); @(negedge clk);
    wr(3, 9, 1); wr(0, 9, 1); wr(12, 9, 1); wr(1, 9, 1);
    readback(3, r); check(r == 2 && rd_off == 0, "R6 out3 unchanged", r, 2);
    readback(1, r); check(r == 1, "R6 out1 unchanged", r, 1);
    check(err == 0, "R6 no err", err, 0);
    gap(2, g); check(g == 2, "R6 out3 gap", g, 2);

    // R7 gating
    wr(5, 5, 1);
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (clk_en[4]) seen++; end
      check(seen == 0, "R7 out5 held low", seen, 0);
    end
    readback(5, r); check(rd_off == 1, "R7 gate read-back", rd_off, 1);
    wr(5, 5, 0);
    gap(4, g); check(g == 5, "R7 out5 resumes", g, 5);
    wr(8, 64, 1);
    readback(8, r); check(rd_off == 0, "R7 out8 gate ignored", rd_off, 0);
    gap(7, g); check(g == 64, "R7 out8 still pulses", g, 64);
    wr(2, 40, 1);
    readback(2, r); check(rd_off == 0, "R5 illegal gate write ignored", rd_off, 0);
    gap(1, g); check(g == 3, "R5 out2 pulses after reject", g, 3);

    // R9 sync
    do_reset();
    repeat (7) @(negedge clk);
    sync = 1'b1;
    @(negedge clk); sync = 1'b0; #0.5;
    check(clk_en == 11'h7FF, "R9 all high after sync", clk_en, 11'h7FF);
    @(negedge clk); #0.5;
    check(clk_en == 11'h001, "R9 only full rate next", clk_en, 11'h001);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule